// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial slave engine of a small non-volatile memory. During a write transaction it gathers the received data bytes into a page-sized holding buffer. It records which buffer slots were filled. When the bus transaction ends with STOP, it copies the filled slots into the memory array and then holds a busy flag for a fixed number of system clocks. The slave engine uses this flag to withhold acknowledgment, so a master can poll the device until the write cycle has finished.

A word address arrives with a load strobe. Each completed data byte then arrives with its own strobe. The byte lands at the current in-page offset, and that offset advances modulo the page size. The page base never changes during a transaction, so bytes written past the page end wrap to the start of the same page. Partial pages are allowed, and only slots that received a byte are written. A write-protect input, sampled at STOP, suppresses programming of the whole array. When the write cycle ends, the shared address counter points one past the last written location, wrapped within the page. The slave engine drops any partially shifted byte itself, so only whole bytes reach this block.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `cur_addr` is 0.
- R2: While idle, a `hdr_load` strobe sets `cur_addr` to `hdr_addr` on the next clock. A `stop_evt` with no data bytes received since that load never asserts `busy` and writes nothing.
- R3: A `stop_evt` after at least one data byte, with `wp` low, raises `busy` on the next clock. `busy` then stays high for exactly `WR_CYCLES` clocks.
- R4: During a write cycle, each received offset is written exactly once, and no other offset is written. Writes go to address {page base, offset} with the page base in `cur_addr[ADDR_W-1:OFF_W]`, at most one per clock, in ascending offset order, with `arr_we` high for one clock per byte.
- R5: Each data byte advances the in-page offset (the low `OFF_W` address bits) by one modulo 2^OFF_W, and the page base stays fixed. A later byte to an offset already filled replaces the earlier data.
- R6: When `busy` falls, `cur_addr` equals {page base, (start offset + bytes received) mod 2^OFF_W}.
- R7: While `busy` is high, `hdr_load`, `byte_stb` and `stop_evt` have no effect. Written data, `cur_addr` and the length of the busy period are unchanged.
- R8: If `wp` is high at STOP, no array write occurs, `busy` stays low, the collected bytes are discarded, and `cur_addr` still advances as in R6.
- R9: `arr_we` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp | input | 1 | Write protect, sampled at STOP |
| hdr_load | input | 1 | Word address strobe from the slave engine |
| hdr_addr | input | ADDR_W | Starting word address |
| byte_stb | input | 1 | One complete data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | STOP condition seen on the bus |
| busy | output | 1 | Write cycle in progress; slave must not acknowledge |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| cur_addr | output | ADDR_W | Shared word address counter |

## Verification
The assertions assume that the slave engine raises each strobe for a single clock and that it never raises `byte_stb` and `stop_evt` together. They also assume that `WR_CYCLES` exceeds the page size, so the copy pass finishes before the timer expires. The stimulus drives one strobe per clock at most, always with a single-cycle pulse. It sweeps every start offset against byte counts from zero to past a full page, so both wrapping and overwrite occur. Strobes raised while `busy` is high are injected deliberately to exercise R7.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [0:0] {CM_IDLE = 1'b0, CM_BUSY = 1'b1} commit_state_t;
endpackage

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       accept,
  input  logic                       hdr_load,
  input  logic [ADDR_W-1:0]          hdr_addr,
  input  logic                       byte_stb,
  input  logic [DATA_W-1:0]          byte_data,
  input  logic                       clr_mask,
  input  logic [OFF_W-1:0]           rd_idx,
  output logic [ADDR_W-OFF_W-1:0]    page_base,
  output logic [OFF_W-1:0]           next_off,
  output logic [(1<<OFF_W)-1:0]      mask,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [DATA_W-1:0] slot_mem [PAGE_BYTES];
  logic              take_hdr;
  logic              take_byte;

  assign take_hdr  = accept && hdr_load;
  assign take_byte = accept && byte_stb && !hdr_load;

  // Slot storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (take_byte) slot_mem[next_off] <= byte_data;
  end

  assign rd_data = slot_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_base <= '0;
      next_off  <= '0;
    end else if (take_hdr) begin
      page_base <= hdr_addr[ADDR_W-1:OFF_W];
      next_off  <= hdr_addr[OFF_W-1:0];
    end else if (take_byte) begin
      next_off  <= next_off + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                        mask[g] <= 1'b0;
      else if (clr_mask || take_hdr)  mask[g] <= 1'b0;
      else if (take_byte && (next_off == OFF_W'(g))) mask[g] <= 1'b1;
    end
  end

  AST_HOLD_WHEN_DEAF: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(page_base) && $stable(next_off))); // R7

  AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (rst)
    take_byte |=> ($stable(page_base) && next_off == $past(next_off) + 1'b1)); // R5

  AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (rst)
    (take_byte && !clr_mask) |=> mask[$past(next_off)]); // R5
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 3,
  parameter int WR_CYCLES = 625000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wp,
  input  logic                       stop_evt,
  input  logic                       hdr_load,
  input  logic [ADDR_W-1:0]          hdr_addr,
  input  logic [(1<<OFF_W)-1:0]      mask,
  input  logic [ADDR_W-OFF_W-1:0]    page_base,
  input  logic [OFF_W-1:0]           next_off,
  input  logic [DATA_W-1:0]          rd_data,
  output logic [OFF_W-1:0]           rd_idx,
  output logic                       clr_mask,
  output logic                       busy,
  output logic                       arr_we,
  output logic [ADDR_W-1:0]          arr_addr,
  output logic [DATA_W-1:0]          arr_wdata,
  output logic [ADDR_W-1:0]          cur_addr
);
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int SCAN_W = OFF_W + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);

  commit_state_t     state;
  logic [CNT_W-1:0]  cnt;
  logic [SCAN_W-1:0] scan;
  logic              have_data;
  logic              start;
  logic              drop;
  logic              done;

  initial assert (WR_CYCLES > (1 << OFF_W));

  assign have_data = |mask;
  assign start     = (state == CM_IDLE) && stop_evt && have_data && !wp;
  assign drop      = (state == CM_IDLE) && stop_evt && have_data && wp;
  assign done      = (state == CM_BUSY) && (cnt == LAST_CNT);
  assign clr_mask  = done || drop;
  assign rd_idx    = scan[OFF_W-1:0];
  assign busy      = (state == CM_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CM_IDLE;
      cnt       <= '0;
      scan      <= '0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      cur_addr  <= '0;
    end else begin
      arr_we <= 1'b0;
      case (state)
        CM_IDLE: begin
          if (start) begin
            state <= CM_BUSY;
            cnt   <= '0;
            scan  <= '0;
          end else if (drop) begin
            cur_addr <= {page_base, next_off};
          end else if (hdr_load) begin
            cur_addr <= hdr_addr;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (!scan[OFF_W]) begin
            arr_we    <= mask[rd_idx];
            arr_addr  <= {page_base, rd_idx};
            arr_wdata <= rd_data;
            scan      <= scan + 1'b1;
          end
          if (done) begin
            state    <= CM_IDLE;
            cur_addr <= {page_base, next_off};
          end
        end
      endcase
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R3

  AST_EMPTY_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && !have_data) |=> !busy); // R2

  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_evt && wp) |=> !busy); // R8

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(cur_addr)); // R7

  AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr[ADDR_W-1:OFF_W] == page_base)); // R4
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 3,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp,
  input  logic              hdr_load,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int BASE_W     = ADDR_W - OFF_W;

  logic [BASE_W-1:0]     page_base;
  logic [OFF_W-1:0]      next_off;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_data;
  logic [OFF_W-1:0]      rd_idx;
  logic                  clr_mask;

  pwb_page_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .accept    (!busy),
    .hdr_load  (hdr_load),
    .hdr_addr  (hdr_addr),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .clr_mask  (clr_mask),
    .rd_idx    (rd_idx),
    .page_base (page_base),
    .next_off  (next_off),
    .mask      (mask),
    .rd_data   (rd_data)
  );

  pwb_commit_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wp        (wp),
    .stop_evt  (stop_evt),
    .hdr_load  (hdr_load),
    .hdr_addr  (hdr_addr),
    .mask      (mask),
    .page_base (page_base),
    .next_off  (next_off),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .clr_mask  (clr_mask),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata),
    .cur_addr  (cur_addr)
  );
endmodule

// File: tb/pwb_page_writer_test.sv
`timescale 1ns/1ps
module pwb_page_writer_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int OW = 3;
  localparam int WR = 20;
  localparam int NP = 1 << OW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp = 1'b0;
  logic hdr_load = 1'b0;
  logic [AW-1:0] hdr_addr = '0;
  logic byte_stb = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic stop_evt = 1'b0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr, cur_addr;
  logic [DW-1:0] arr_wdata;

  always #4 clk = ~clk;

  pwb_page_writer #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .WR_CYCLES(WR)) uut (
    .clk(clk), .rst(rst), .wp(wp), .hdr_load(hdr_load), .hdr_addr(hdr_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .stop_evt(stop_evt),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .cur_addr(cur_addr)
  );

  int checks = 0;
  int errors = 0;

  int seen_cnt [NP];
  logic [DW-1:0] seen_data [NP];
  int prev_off;
  int order_bad;
  int page_bad;
  int we_idle;
  int cur_page;

  always @(negedge clk) begin
    if (!rst && arr_we) begin
      int o;
      o = int'(arr_addr[OW-1:0]);
      if (!busy) we_idle++;
      if (int'(arr_addr[AW-1:OW]) != cur_page) page_bad++;
      if (o <= prev_off) order_bad++;
      prev_off = o;
      seen_cnt[o]++;
      seen_data[o] = arr_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int page, input int start, input int n, input int k);
    return DW'(page * 7 + start * 37 + n * 11 + k * 5 + 1);
  endfunction

  task automatic run_txn(input int page, input int start, input int n,
                         input bit wpv, input bit noise);
    bit exp_mask [NP];
    logic [DW-1:0] exp_data [NP];
    int off, bc, exp_busy, exp_cur;
    for (int o = 0; o < NP; o++) begin
      exp_mask[o] = 1'b0; exp_data[o] = '0;
      seen_cnt[o] = 0;
    end
    off = start;
    for (int k = 0; k < n; k++) begin
      exp_mask[off] = 1'b1;
      exp_data[off] = pat(page, start, n, k);
      off = (off + 1) % NP;
    end
    prev_off = -1; order_bad = 0; page_bad = 0; cur_page = page;
    wp = wpv;
    hdr_addr = AW'(page * NP + start);
    hdr_load = 1'b1;
    @(negedge clk);
    hdr_load = 1'b0;
    chk("R2 header loads cur_addr", int'(cur_addr), page * NP + start);
    for (int k = 0; k < n; k++) begin
      byte_data = pat(page, start, n, k);
      byte_stb = 1'b1;
      @(negedge clk);
      byte_stb = 1'b0;
    end
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    bc = 0;
    while (busy && bc < WR + 50) begin
      bc++;
      if (noise && bc < 6) begin
        hdr_load = 1'b1; hdr_addr = AW'(page * NP + start) ^ 8'hA5;
        byte_stb = 1'b1; byte_data = 8'h5A; stop_evt = 1'b1;
      end else begin
        hdr_load = 1'b0; byte_stb = 1'b0; stop_evt = 1'b0;
      end
      @(negedge clk);
    end
    hdr_load = 1'b0; byte_stb = 1'b0; stop_evt = 1'b0;
    @(negedge clk);
    exp_busy = (n > 0 && !wpv) ? WR : 0;
    exp_cur  = page * NP + (start + n) % NP;
    if (wpv)        chk("R8 no busy under write protect", bc, 0);
    else if (n == 0) chk("R2 empty header gives no busy", bc, 0);
    else if (noise) chk("R7 busy length with ignored strobes", bc, exp_busy);
    else            chk("R3 busy length", bc, exp_busy);
    for (int o = 0; o < NP; o++) begin
      if (wpv) chk("R8 no write under protect", seen_cnt[o], 0);
      else     chk("R4 write count per offset", seen_cnt[o], int'(exp_mask[o]));
      if (!wpv && exp_mask[o] && seen_cnt[o] == 1)
        chk("R5 written data at offset", int'(seen_data[o]), int'(exp_data[o]));
    end
    chk("R4 ascending offset order", order_bad, 0);
    chk("R4 writes stay in page", page_bad, 0);
    if (noise)     chk("R7 cur_addr unaffected by ignored strobes", int'(cur_addr), exp_cur);
    else if (wpv)  chk("R8 cur_addr advances under protect", int'(cur_addr), exp_cur);
    else           chk("R6 cur_addr after write cycle", int'(cur_addr), exp_cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    we_idle = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 arr_we after reset", int'(arr_we), 0);
    chk("R1 cur_addr after reset", int'(cur_addr), 0);
    for (int s = 0; s < NP; s++) begin
      for (int n = 0; n <= NP + 2; n++) begin
        run_txn((s * 5 + n) % 32, s, n, 1'b0, 1'b0);
      end
    end
    run_txn(9, 6, 5, 1'b1, 1'b0);
    run_txn(9, 2, 1, 1'b0, 1'b0);
    run_txn(31, 0, 8, 1'b1, 1'b0);
    run_txn(31, 7, 2, 1'b0, 1'b0);
    run_txn(4, 3, 4, 1'b0, 1'b1);
    run_txn(17, 7, 9, 1'b0, 1'b1);
    run_txn(0, 0, 0, 1'b1, 1'b0);
    chk("R9 no array write while idle", we_idle, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule